// File: doc/BRIEF.md
# DRAM Bank Row-Cycle Scheduler

This block takes read requests, each for one 8-beat burst, and converts every request into a closed-page access on a single DRAM command bus. Each access is an activate, then a read that carries auto-precharge, then the precharge recovery that the device performs on its own. The block splits the request address into bank, row and burst column fields. A countdown per bank stops that bank from being activated again before its full row cycle has passed. Accesses to different banks therefore overlap, and the command and data buses stay busy.

Requests enter through a valid/ready handshake and are served strictly in arrival order. When a read comes due on the same clock as a new activate, the read takes the command slot. A read-data-valid strobe, carrying the tag of its request, marks the four clocks on which the burst data will be on the data bus. The timing values are parameters, and the row-cycle time is derived from them. With the defaults (19/19/19 clocks and a 4-clock burst), a bank is busy for 61 clocks after each activate.

Top module: `dram_bank_sched`

## Requirements
- R1: The request address is {bank[27:24], row[23:7], burst column[6:0]}. An activate drives that bank and row onto the command bus. A read drives the same bank with a 10-bit device column of {burst column, 3'b000}.
- R2: The command code is 2'b00 for idle, 2'b01 for activate and 2'b10 for read with auto-precharge. An activate appears on the bus in the clock that follows the edge on which its request was accepted.
- R3: A bank accepts no new request until T_RC (61 by default) clocks after its previous activate. A second request to the same bank is accepted exactly 61 clocks after the first, provided nothing else blocks it.
- R4: The read for a request is issued exactly T_RCD (19) clocks after its activate. The read carries the request's bank and column.
- R5: Two activates are always at least BURST_CLKS (4) clocks apart, so that data bursts on the shared data bus never collide.
- R6: When a read falls due on the same clock that an activate could be accepted, the read is issued and the activate is accepted one clock later.
- R7: The read-data-valid strobe is high for exactly 4 clocks, starting T_CAS (19) clocks after each read command. The tag output holds the tag of the request that issued that read.
- R8: Ready stays low for the whole lockout while the head request targets a busy bank, even when every other bank is idle. No later request is served ahead of it.
- R9: After reset the command bus is idle, the strobe is low and every bank is free, so ready is high.
- R10: Requests to distinct idle banks are accepted every BURST_CLKS clocks, and their row cycles overlap.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Command clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Head request present |
| req_ready | output | 1 | Head request is accepted on this edge |
| req_addr | input | 28 | Bank, row and burst column of the request |
| req_tag | input | 4 | Identifier returned with the data strobe |
| cmd_kind | output | 2 | Command code: idle, activate or read with auto-precharge |
| cmd_bank | output | 4 | Bank of the current command |
| cmd_row | output | 17 | Row of an activate (zero otherwise) |
| cmd_col | output | 10 | Device column of a read (zero otherwise) |
| rd_valid | output | 1 | Burst data valid on the data bus |
| rd_tag | output | 4 | Tag of the burst now on the data bus |

## Verification
The assertions check several rules on every clock: no activate ever reaches a bank whose row-cycle countdown is still running, no two activates fall on adjacent clocks, a due read always takes the command slot, and no new data burst starts while an earlier one still has more than its last beat to run. The exact cycle counts can only be shown by the directed scenarios. These are the 19-clock activate-to-read gap, the 19-clock read-to-data gap, the 61-clock same-bank reuse and the one-clock slip of an activate that collides with a read. The scenarios also show the field decode, the tag that returns with each burst, and the in-order stall while a locked-out bank heads the queue.

// File: rtl/dram_sched_pkg.sv
package dram_sched_pkg;

    typedef enum logic [1:0] {
        CMD_NOP = 2'b00,
        CMD_ACT = 2'b01,
        CMD_RDA = 2'b10
    } cmd_e;

    // Full closed-page row cycle: open, read latency, burst, then recovery.
    function automatic int row_cycle_clks(int rcd, int cas, int burst, int rp);
        return rcd + cas + burst + rp;
    endfunction

endpackage

// File: rtl/sched_delay_line.sv
module sched_delay_line #(
    parameter int DEPTH = 19,
    parameter int W     = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         in_valid,
    input  logic [W-1:0] in_data,
    output logic         out_valid,
    output logic [W-1:0] out_data
);
    logic [DEPTH-1:0] vld_q;
    logic [W-1:0]     dat_q [DEPTH];

    always_ff @(posedge clk) begin
        if (rst) vld_q[0] <= 1'b0;
        else     vld_q[0] <= in_valid;
        dat_q[0] <= in_data;
    end

    for (genvar s = 1; s < DEPTH; s++) begin : g_stage
        always_ff @(posedge clk) begin
            if (rst) vld_q[s] <= 1'b0;
            else     vld_q[s] <= vld_q[s-1];
            dat_q[s] <= dat_q[s-1];
        end
    end

    assign out_valid = vld_q[DEPTH-1];
    assign out_data  = dat_q[DEPTH-1];

endmodule

// File: rtl/sched_bank_timers.sv
module sched_bank_timers #(
    parameter int BANK_W = 4,
    parameter int T_RC   = 61
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   act_valid,
    input  logic [BANK_W-1:0]      act_bank,
    output logic [(1<<BANK_W)-1:0] bank_free
);
    localparam int NBANKS = 1 << BANK_W;
    localparam int CNT_W  = $clog2(T_RC + 1);

    for (genvar b = 0; b < NBANKS; b++) begin : g_bank
        logic [CNT_W-1:0] left_q;
        logic             hit;

        assign hit = act_valid && (act_bank == BANK_W'(b));

        always_ff @(posedge clk) begin
            if (rst)               left_q <= '0;
            else if (hit)          left_q <= CNT_W'(T_RC - 1);
            else if (left_q != '0) left_q <= left_q - 1'b1;
        end

        assign bank_free[b] = (left_q == '0);

        // R3: a bank is only opened once its row cycle has fully elapsed
        p_no_early_act_r3: assert property (@(posedge clk) disable iff (rst)
            hit |-> (left_q == '0));
    end

endmodule

// File: rtl/dram_bank_sched.sv
module dram_bank_sched
    import dram_sched_pkg::*;
#(
    parameter int BANK_W     = 4,
    parameter int ROW_W      = 17,
    parameter int COL_W      = 7,
    parameter int BEATS      = 8,
    parameter int TAG_W      = 4,
    parameter int T_RCD      = 19,
    parameter int T_CAS      = 19,
    parameter int T_RP       = 19,
    parameter int BURST_CLKS = 4
) (
    input  logic                             clk,
    input  logic                             rst,
    input  logic                             req_valid,
    output logic                             req_ready,
    input  logic [BANK_W+ROW_W+COL_W-1:0]    req_addr,
    input  logic [TAG_W-1:0]                 req_tag,
    output logic [1:0]                       cmd_kind,
    output logic [BANK_W-1:0]                cmd_bank,
    output logic [ROW_W-1:0]                 cmd_row,
    output logic [COL_W+$clog2(BEATS)-1:0]   cmd_col,
    output logic                             rd_valid,
    output logic [TAG_W-1:0]                 rd_tag
);
    localparam int NBANKS = 1 << BANK_W;
    localparam int ADDR_W = BANK_W + ROW_W + COL_W;
    localparam int BEAT_W = $clog2(BEATS);
    localparam int T_RC   = row_cycle_clks(T_RCD, T_CAS, BURST_CLKS, T_RP);
    localparam int GAP_W  = $clog2(BURST_CLKS + 1);

    typedef struct packed {
        logic [TAG_W-1:0]  tag;
        logic [BANK_W-1:0] bank;
        logic [COL_W-1:0]  col;
    } rd_slot_t;

    // Address decode
    logic [BANK_W-1:0] req_bank;
    logic [ROW_W-1:0]  req_row;
    logic [COL_W-1:0]  req_col;
    assign req_bank = req_addr[ADDR_W-1 -: BANK_W];
    assign req_row  = req_addr[COL_W +: ROW_W];
    assign req_col  = req_addr[COL_W-1:0];

    logic [NBANKS-1:0] bank_free;
    logic [GAP_W-1:0]  gap_q;
    logic              rd_due;
    rd_slot_t          rd_slot;
    logic              accept;

    assign req_ready = bank_free[req_bank] && (gap_q == '0) && !rd_due;
    assign accept    = req_valid && req_ready;

    sched_bank_timers #(.BANK_W(BANK_W), .T_RC(T_RC)) u_timers (
        .clk       (clk),
        .rst       (rst),
        .act_valid (accept),
        .act_bank  (req_bank),
        .bank_free (bank_free)
    );

    // Activate-to-read pipeline: a read falls due T_RCD clocks after its activate
    rd_slot_t act_slot;
    assign act_slot = '{tag: req_tag, bank: req_bank, col: req_col};

    sched_delay_line #(.DEPTH(T_RCD), .W($bits(rd_slot_t))) u_rcd_pipe (
        .clk       (clk),
        .rst       (rst),
        .in_valid  (accept),
        .in_data   (act_slot),
        .out_valid (rd_due),
        .out_data  (rd_slot)
    );

    // Minimum spacing between activates keeps bursts apart on the data bus
    always_ff @(posedge clk) begin
        if (rst)              gap_q <= '0;
        else if (accept)      gap_q <= GAP_W'(BURST_CLKS - 1);
        else if (gap_q != '0) gap_q <= gap_q - 1'b1;
    end

    // Command register: a due read wins the single slot
    cmd_e cmd_q;
    always_ff @(posedge clk) begin
        if (rst) begin
            cmd_q    <= CMD_NOP;
            cmd_bank <= '0;
            cmd_row  <= '0;
            cmd_col  <= '0;
        end else if (rd_due) begin
            cmd_q    <= CMD_RDA;
            cmd_bank <= rd_slot.bank;
            cmd_row  <= '0;
            cmd_col  <= {rd_slot.col, {BEAT_W{1'b0}}};
        end else if (accept) begin
            cmd_q    <= CMD_ACT;
            cmd_bank <= req_bank;
            cmd_row  <= req_row;
            cmd_col  <= '0;
        end else begin
            cmd_q    <= CMD_NOP;
            cmd_bank <= '0;
            cmd_row  <= '0;
            cmd_col  <= '0;
        end
    end
    assign cmd_kind = cmd_q;

    // Read-to-data pipeline and burst strobe
    logic             data_start;
    logic [TAG_W-1:0] data_tag;

    sched_delay_line #(.DEPTH(T_CAS), .W(TAG_W)) u_cas_pipe (
        .clk       (clk),
        .rst       (rst),
        .in_valid  (rd_due),
        .in_data   (rd_slot.tag),
        .out_valid (data_start),
        .out_data  (data_tag)
    );

    logic [GAP_W-1:0] beat_q;
    always_ff @(posedge clk) begin
        if (rst) begin
            beat_q <= '0;
            rd_tag <= '0;
        end else if (data_start) begin
            beat_q <= GAP_W'(BURST_CLKS);
            rd_tag <= data_tag;
        end else if (beat_q != '0) begin
            beat_q <= beat_q - 1'b1;
        end
    end
    assign rd_valid = (beat_q != '0);

    // R5: two activates never land on neighbouring clocks
    p_act_gap_r5: assert property (@(posedge clk) disable iff (rst)
        (cmd_q == CMD_ACT) |=> (cmd_q != CMD_ACT));

    // R6: a read that falls due always takes the next command slot
    p_read_first_r6: assert property (@(posedge clk) disable iff (rst)
        rd_due |=> (cmd_q == CMD_RDA));

    // R7: a new burst starts only on or after the last beat of the previous one
    p_burst_no_overlap_r7: assert property (@(posedge clk) disable iff (rst)
        data_start |-> (beat_q <= GAP_W'(1)));

endmodule

// File: tb/dram_bank_sched_bench.sv
module dram_bank_sched_bench;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic [27:0] req_addr = '0;
    logic [3:0]  req_tag = '0;
    logic [1:0]  cmd_kind;
    logic [3:0]  cmd_bank;
    logic [16:0] cmd_row;
    logic [9:0]  cmd_col;
    logic        rd_valid;
    logic [3:0]  rd_tag;

    int cyc = 0;
    int n_chk = 0;
    int n_bad = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    dram_bank_sched u_dram_bank_sched (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
        .req_addr(req_addr), .req_tag(req_tag), .cmd_kind(cmd_kind),
        .cmd_bank(cmd_bank), .cmd_row(cmd_row), .cmd_col(cmd_col),
        .rd_valid(rd_valid), .rd_tag(rd_tag)
    );

    // Bus monitor: logs every command and data beat with its cycle number
    int          act_n = 0, rd_n = 0, dv_n = 0;
    int          act_t [256];
    logic [3:0]  act_b [256];
    logic [16:0] act_r [256];
    int          rd_t  [256];
    logic [3:0]  rd_b  [256];
    logic [9:0]  rd_c  [256];
    int          dv_t  [256];
    logic [3:0]  dv_g  [256];

    always @(negedge clk) begin
        if (!rst) begin
            if (cmd_kind == 2'b01 && act_n < 256) begin
                act_t[act_n] = cyc; act_b[act_n] = cmd_bank; act_r[act_n] = cmd_row;
                act_n = act_n + 1;
            end
            if (cmd_kind == 2'b10 && rd_n < 256) begin
                rd_t[rd_n] = cyc; rd_b[rd_n] = cmd_bank; rd_c[rd_n] = cmd_col;
                rd_n = rd_n + 1;
            end
            if (rd_valid && dv_n < 256) begin
                dv_t[dv_n] = cyc; dv_g[dv_n] = rd_tag;
                dv_n = dv_n + 1;
            end
        end
    end

    task automatic chk(input string req, input string what, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    // Present one request; returns the acceptance edge and the clocks spent waiting
    task automatic send(input logic [3:0] bank, input logic [16:0] row, input logic [6:0] col,
                        input logic [3:0] tag, output int acc, output int waits);
        waits = 0;
        req_valid = 1'b1;
        req_addr  = {bank, row, col};
        req_tag   = tag;
        #1;
        while (!req_ready) begin
            waits++;
            @(negedge clk);
            #1;
        end
        acc = cyc + 1;
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic test_reset;
        chk("R9", "cmd_kind after reset", int'(cmd_kind), 0);
        chk("R9", "rd_valid after reset", int'(rd_valid), 0);
        chk("R9", "req_ready after reset", int'(req_ready), 1);
    endtask

    task automatic test_single;
        int ab, rb, db, acc, w;
        ab = act_n; rb = rd_n; db = dv_n;
        send(4'd3, 17'h1ABCD, 7'h55, 4'd5, acc, w);
        idle(60);
        chk("R2", "activate count", act_n - ab, 1);
        chk("R2", "activate cycle", act_t[ab], acc);
        chk("R1", "activate bank", int'(act_b[ab]), 3);
        chk("R1", "activate row", int'(act_r[ab]), 'h1ABCD);
        chk("R4", "read cycle", rd_t[rb], acc + 19);
        chk("R1", "read bank", int'(rd_b[rb]), 3);
        chk("R1", "read device column", int'(rd_c[rb]), 'h2A8);
        chk("R7", "beats", dv_n - db, 4);
        chk("R7", "first beat cycle", dv_t[db], acc + 38);
        chk("R7", "last beat cycle", dv_t[db + 3], acc + 41);
        chk("R7", "beat tag", int'(dv_g[db]), 5);
    endtask

    task automatic test_same_bank;
        int ab, a1, a2, w1, w2;
        ab = act_n;
        send(4'd7, 17'h00010, 7'h01, 4'd1, a1, w1);
        send(4'd7, 17'h00020, 7'h02, 4'd2, a2, w2);
        chk("R3", "same-bank reuse distance", a2 - a1, 61);
        chk("R8", "clocks with ready low on locked head", w2, 60);
        idle(3);
        chk("R8", "activates issued in window", act_n - ab, 2);
        idle(80);
    endtask

    task automatic test_stream;
        int rb, db, w;
        int acc [4];
        rb = rd_n; db = dv_n;
        for (int k = 0; k < 4; k++)
            send(4'(k), 17'(k * 3 + 1), 7'(k + 8), 4'(k + 10), acc[k], w);
        idle(70);
        for (int k = 1; k < 4; k++) begin
            chk("R5", "activate spacing", acc[k] - acc[k-1], 4);
            chk("R10", "distinct banks overlap", int'(acc[k] < acc[0] + 61), 1);
        end
        for (int k = 0; k < 4; k++) begin
            chk("R4", "streamed read cycle", rd_t[rb + k], acc[k] + 19);
            chk("R7", "streamed burst start", dv_t[db + 4 * k], acc[k] + 38);
            chk("R7", "streamed burst tag", int'(dv_g[db + 4 * k + 3]), k + 10);
        end
        chk("R7", "streamed beat total", dv_n - db, 16);
        idle(20);
    endtask

    task automatic test_collision;
        int ab, rb, a1, a2, w;
        ab = act_n; rb = rd_n;
        send(4'd9, 17'h00100, 7'h11, 4'd6, a1, w);
        while (cyc < a1 + 18) @(negedge clk);
        send(4'd10, 17'h00200, 7'h22, 4'd7, a2, w);
        idle(60);
        chk("R6", "colliding read cycle", rd_t[rb], a1 + 19);
        chk("R6", "delayed activate accept", a2, a1 + 20);
        chk("R6", "delayed activate on bus", act_t[ab + 1], a1 + 20);
        chk("R6", "delayed activate bank", int'(act_b[ab + 1]), 10);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        test_reset();
        test_single();
        test_same_bank();
        test_stream();
        test_collision();
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (50000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

endmodule